// File: doc/BRIEF.md
# Decimal Shift-and-Add Multiplier

This block multiplies two unsigned packed-decimal integers, each made of `DIGITS` four-bit decimal digits, over several clock cycles. The product is kept to the same number of digits. Any part of the product at or above 10^DIGITS is dropped. A pulse on `start` captures both operands. `busy` stays high while the work runs. A single-cycle `done` marks the cycle in which `product` becomes valid. The product then holds until the next accepted start.

There is only one arithmetic element, a decimal word adder with one digit slice per decimal position. It is time-shared between two uses. The first adds a scaled copy of the multiplicand into the accumulator. The second doubles that scaled copy in place. The multiplier is consumed one decimal digit at a time, starting with the least significant digit. The four bits of each digit are taken in the order of weights 1, 2, 4, 8. After the weight-8 bit, the scaled copy is not doubled again. It is rebuilt from the multiplicand moved up by one more digit position, because a further doubling would give a factor of sixteen where a factor of ten is needed. The run stops as soon as the multiplier digits still waiting are all zero.

Top module: `bcd_shift_mul`

## Requirements
- R1: While reset is active and after it is released, `busy` and `done` are low and `product` is zero.
- R2: For operands made of decimal digits, `product` equals multiplicand × multiplier mod 10^DIGITS. Decimal digit i of every bus sits in bits [4i+3:4i].
- R3: `done` is high for exactly one cycle, and `busy` is low in that cycle. From then until the next accepted start, `product` does not change.
- R4: Let the start be sampled at clock edge E0, and let n be the position of the most significant nonzero multiplier digit plus one. `done` becomes high right after edge E0+8n. When the multiplier is zero, n is 0 and the product is zero.
- R5: A `start` asserted while `busy` is high is ignored. The result and the timing of the running operation are unchanged.
- R6: Carries out of the most significant digit are dropped. For example, 999…9 × 999…9 gives 000…01, and 5×10^(DIGITS-1) × 2 gives zero.
- R7: `busy` rises in the cycle after an accepted start with a nonzero multiplier. It stays high without a break until the cycle of `done`.
- R8: The accumulator is cleared on every accepted start, so a result never carries any part of the previous one.
- R9: The operand buses are sampled only at the accepted start. Changes on them while `busy` is high have no effect on the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new multiply; accepted only while idle |
| multiplicand | input | 4*DIGITS | Packed decimal multiplicand |
| multiplier | input | 4*DIGITS | Packed decimal multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product valid |
| product | output | 4*DIGITS | Packed decimal product, low DIGITS digits |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of a run, together with operand buses that change under a busy unit. The bench forces this case directly. One cycle into the run, it raises `start` with complemented, non-decimal operands, then holds the buses at that garbage until `done`. A correct product and an unchanged latency then show that both the request and the bus changes were ignored. The longest schedule (only the top multiplier digit nonzero) and the dropped top carries come from directed wide operands. A two-digit instance is swept across every multiplicand against every one-digit multiplier and a stride of two-digit multipliers.

// File: rtl/bcdmul_pkg.sv
package bcdmul_pkg;

   // Sequencer phases: idle, conditional accumulate, doubling / reseed
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADD  = 2'd1,
      ST_DBL  = 2'd2
   } mul_state_e;

   localparam int NIBBLE     = 4;
   localparam int BITS_PER_D = 4;

endpackage

// File: rtl/bcd_word_add.sv
// Ripple decimal adder over DIGITS packed digits, carry-in zero,
// carry out of the top digit dropped (result is modulo 10^DIGITS).
module bcd_word_add #(
   parameter int DIGITS     = 16,
   parameter int CORR_STYLE = 0
) (
   input  logic [4*DIGITS-1:0] a,
   input  logic [4*DIGITS-1:0] b,
   output logic [4*DIGITS-1:0] sum
);
   localparam int W = 4 * DIGITS;

   generate
      if (CORR_STYLE == 0) begin : g_cmp
         // correction decided by magnitude compare of the raw digit sum
         always_comb begin : chain
            logic       cy;
            logic [4:0] raw;
            cy  = 1'b0;
            sum = '0;
            for (int i = 0; i < DIGITS; i++) begin
               raw = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0000, cy};
               cy  = (raw > 5'd9);
               sum[4*i +: 4] = cy ? (raw[3:0] + 4'd6) : raw[3:0];
            end
         end
      end else begin : g_gate
         // correction decided by a two-level gate term on the raw bits
         always_comb begin : chain
            logic       cy;
            logic [4:0] raw;
            cy  = 1'b0;
            sum = '0;
            for (int i = 0; i < DIGITS; i++) begin
               raw = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0000, cy};
               cy  = raw[4] | (raw[3] & (raw[2] | raw[1]));
               sum[4*i +: 4] = cy ? (raw[3:0] + 4'd6) : raw[3:0];
            end
         end
      end
   endgenerate

   if (W < 4) begin : g_bad_width
      $error("bcd_word_add: DIGITS must be at least 1");
   end

endmodule

// File: rtl/bcdmul_ctrl.sv
// Digit/bit sequencer: walks multiplier digits low to high, bit weights
// 1,2,4,8 within a digit, one adder operation per cycle.
module bcdmul_ctrl
   import bcdmul_pkg::*;
#(
   parameter int DIGITS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [4*DIGITS-1:0] multiplier,
   output logic                busy,
   output logic                done,
   output logic                load,
   output logic                acc_we,
   output logic                dbl_we,
   output logic                reseed,
   output logic                sel_dbl
);
   localparam int W        = 4 * DIGITS;
   localparam int LAST_BIT = BITS_PER_D - 1;

   mul_state_e     state;
   logic [1:0]     bit_idx;
   logic [W-1:0]   rem;
   logic [W-1:0]   rem_next;
   logic [3:0]     cur_nib;
   logic           last_bit;
   logic           more;

   always_comb begin
      rem_next = rem >> NIBBLE;
      more     = |rem_next;
      cur_nib  = rem[3:0];
      last_bit = (bit_idx == 2'(LAST_BIT));
   end

   always_comb begin
      busy    = (state != ST_IDLE);
      load    = (state == ST_IDLE) && start;
      acc_we  = (state == ST_ADD) && cur_nib[bit_idx];
      sel_dbl = (state == ST_DBL);
      dbl_we  = (state == ST_DBL) && !last_bit;
      reseed  = (state == ST_DBL) && last_bit && more;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_idx <= '0;
         rem     <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  rem     <= multiplier;
                  bit_idx <= '0;
                  if (|multiplier) state <= ST_ADD;
                  else             done  <= 1'b1;
               end
            end
            ST_ADD: begin
               state <= ST_DBL;
            end
            ST_DBL: begin
               if (!last_bit) begin
                  bit_idx <= bit_idx + 2'd1;
                  state   <= ST_ADD;
               end else begin
                  bit_idx <= '0;
                  if (more) begin
                     rem   <= rem_next;
                     state <= ST_ADD;
                  end else begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bcdmul_data.sv
// Accumulator, scaled multiplicand copy and seed register around the
// single shared decimal adder.
module bcdmul_data #(
   parameter int DIGITS     = 16,
   parameter int CORR_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [4*DIGITS-1:0] multiplicand,
   input  logic                load,
   input  logic                acc_we,
   input  logic                dbl_we,
   input  logic                reseed,
   input  logic                sel_dbl,
   output logic [4*DIGITS-1:0] product
);
   localparam int W = 4 * DIGITS;

   logic [W-1:0] acc;
   logic [W-1:0] wk;
   logic [W-1:0] seed;
   logic [W-1:0] seed_up;
   logic [W-1:0] op_a;
   logic [W-1:0] sum;

   always_comb begin
      op_a    = sel_dbl ? wk : acc;
      seed_up = seed << bcdmul_pkg::NIBBLE;
   end

   bcd_word_add #(
      .DIGITS     (DIGITS),
      .CORR_STYLE (CORR_STYLE)
   ) u_add (
      .a   (op_a),
      .b   (wk),
      .sum (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         wk   <= '0;
         seed <= '0;
      end else if (load) begin
         acc  <= '0;
         wk   <= multiplicand;
         seed <= multiplicand;
      end else begin
         if (acc_we) acc <= sum;
         if (dbl_we) wk  <= sum;
         if (reseed) begin
            seed <= seed_up;
            wk   <= seed_up;
         end
      end
   end

   assign product = acc;

endmodule

// File: rtl/bcd_shift_mul.sv
// Multi-cycle packed-decimal multiplier, product truncated to DIGITS digits.
module bcd_shift_mul #(
   parameter int DIGITS     = 16,
   parameter int CORR_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [4*DIGITS-1:0] multiplicand,
   input  logic [4*DIGITS-1:0] multiplier,
   output logic                busy,
   output logic                done,
   output logic [4*DIGITS-1:0] product
);
   localparam int W = 4 * DIGITS;

   if (DIGITS < 1) begin : g_bad_digits
      $error("bcd_shift_mul: DIGITS must be at least 1");
   end
   if (CORR_STYLE < 0 || CORR_STYLE > 1) begin : g_bad_style
      $error("bcd_shift_mul: CORR_STYLE must be 0 or 1");
   end

   logic load, acc_we, dbl_we, reseed, sel_dbl;

   bcdmul_ctrl #(
      .DIGITS (DIGITS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .multiplier (multiplier),
      .busy       (busy),
      .done       (done),
      .load       (load),
      .acc_we     (acc_we),
      .dbl_we     (dbl_we),
      .reseed     (reseed),
      .sel_dbl    (sel_dbl)
   );

   bcdmul_data #(
      .DIGITS     (DIGITS),
      .CORR_STYLE (CORR_STYLE)
   ) u_data (
      .clk          (clk),
      .rst_n        (rst_n),
      .multiplicand (multiplicand[W-1:0]),
      .load         (load),
      .acc_we       (acc_we),
      .dbl_we       (dbl_we),
      .reseed       (reseed),
      .sel_dbl      (sel_dbl),
      .product      (product)
   );

endmodule

// File: rtl/bcdmul_chk.sv
module bcdmul_chk #(
   parameter int DIGITS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                busy,
   input logic                done,
   input logic [4*DIGITS-1:0] product
);
   localparam int LIM = 8 * DIGITS;
   localparam int CW  = $clog2(LIM + 2) + 1;

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_cnt <= '0;
      else if (start && !busy)  run_cnt <= CW'(1);
      else if (busy)            run_cnt <= run_cnt + CW'(1);
      else                      run_cnt <= '0;
   end

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !done);

   // R3
   prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(product));

   // R7
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy || done);

   // R7
   busy_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> busy || done);

   // R7
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R4
   latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_cnt <= CW'(LIM));

endmodule

bind bcd_shift_mul bcdmul_chk #(.DIGITS(DIGITS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .product (product)
);

// File: tb/bcd_shift_mul_test.sv
module bcd_shift_mul_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // two-digit instance
   logic        s_start = 1'b0;
   logic [7:0]  s_a = '0, s_b = '0;
   logic        s_busy, s_done;
   logic [7:0]  s_prod;
   // sixteen-digit instance
   logic        w_start = 1'b0;
   logic [63:0] w_a = '0, w_b = '0;
   logic        w_busy, w_done;
   logic [63:0] w_prod;

   bcd_shift_mul #(.DIGITS(2), .CORR_STYLE(1)) uut (
      .clk(clk), .rst_n(rst_n), .start(s_start), .multiplicand(s_a),
      .multiplier(s_b), .busy(s_busy), .done(s_done), .product(s_prod));

   bcd_shift_mul #(.DIGITS(16), .CORR_STYLE(0)) uut_wide (
      .clk(clk), .rst_n(rst_n), .start(w_start), .multiplicand(w_a),
      .multiplier(w_b), .busy(w_busy), .done(w_done), .product(w_prod));

   int total = 0;
   int bad = 0;
   bit cur_wide = 1'b0;

   logic        sel_done, sel_busy;
   logic [63:0] sel_prod;
   assign sel_done = cur_wide ? w_done : s_done;
   assign sel_busy = cur_wide ? w_busy : s_busy;
   assign sel_prod = cur_wide ? w_prod : {56'd0, s_prod};

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // schoolbook decimal product modulo 10^nd
   function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b,
                                           input int nd);
      int col[16];
      int carry;
      logic [63:0] r;
      for (int i = 0; i < 16; i++) col[i] = 0;
      for (int i = 0; i < nd; i++)
         for (int j = 0; j < nd; j++)
            if (i + j < nd) col[i+j] += int'(a[4*i +: 4]) * int'(b[4*j +: 4]);
      carry = 0;
      r = '0;
      for (int i = 0; i < nd; i++) begin
         col[i] += carry;
         r[4*i +: 4] = 4'(col[i] % 10);
         carry = col[i] / 10;
      end
      return r;
   endfunction

   function automatic int ref_lat(input logic [63:0] b, input int nd);
      int n = 0;
      for (int j = 0; j < nd; j++) if (b[4*j +: 4] != 4'd0) n = j + 1;
      return 8 * n;
   endfunction

   function automatic logic [63:0] to_bcd2(input int v);
      logic [63:0] r = '0;
      r[7:4] = 4'(v / 10);
      r[3:0] = 4'(v % 10);
      return r;
   endfunction

   task automatic drive(input bit st, input logic [63:0] a, input logic [63:0] b);
      if (cur_wide) begin
         w_start = st; w_a = a; w_b = b;
      end else begin
         s_start = st; s_a = a[7:0]; s_b = b[7:0];
      end
   endtask

   // disturb: mid-run start with garbage operands, buses held at garbage (R5, R9)
   task automatic run_op(input bit wide, input logic [63:0] a, input logic [63:0] b,
                         input bit disturb, input bit hold, input string req);
      int nd, lat, cnt;
      logic [63:0] exp, snap;
      cur_wide = wide;
      nd  = wide ? 16 : 2;
      exp = ref_mul(a, b, nd);
      lat = ref_lat(b, nd);
      @(negedge clk);
      drive(1'b1, a, b);
      @(posedge clk);
      @(negedge clk);
      drive(1'b0, a, b);
      cnt = 0;
      while (!sel_done && cnt < 300) begin
         if (disturb && cnt == 1) drive(1'b1, ~a, ~b);
         else if (disturb)        drive(1'b0, ~a, ~b);
         @(negedge clk);
         cnt++;
      end
      drive(1'b0, a, b);
      chk(cnt == lat, {req, " R4 latency"}, 64'(cnt), 64'(lat));
      chk(sel_prod == exp, {req, " R2 product"}, sel_prod, exp);
      chk(!sel_busy, "R3 busy low with done", {63'd0, sel_busy}, 64'd0);
      if (hold) begin
         snap = sel_prod;
         repeat (3) @(negedge clk);
         chk(sel_prod == snap, "R3 product held", sel_prod, snap);
         chk(!sel_done, "R3 done single cycle", {63'd0, sel_done}, 64'd0);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(!s_busy && !s_done && s_prod == 8'd0, "R1 reset small",
          {56'd0, s_prod}, 64'd0);
      chk(!w_busy && !w_done && w_prod == 64'd0, "R1 reset wide", w_prod, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!s_busy && !s_done && s_prod == 8'd0, "R1 after release small",
          {56'd0, s_prod}, 64'd0);
      chk(!w_busy && !w_done && w_prod == 64'd0, "R1 after release wide",
          w_prod, 64'd0);

      // directed wide cases
      run_op(1'b1, 64'h9999999999999999, 64'h9999999999999999, 1'b0, 1'b1,
             "R6 all nines");
      run_op(1'b1, 64'h0000000000000002, 64'h0000000000000003, 1'b0, 1'b0,
             "R8 fresh accumulator");
      run_op(1'b1, 64'h0000000012345678, 64'h0000000087654321, 1'b0, 1'b1,
             "R2 eight by eight");
      run_op(1'b1, 64'h0000000000000007, 64'h9000000000000000, 1'b0, 1'b0,
             "R4 R6 top digit only");
      run_op(1'b1, 64'h1234567890123456, 64'h0000000000000000, 1'b0, 1'b1,
             "R4 zero multiplier");
      run_op(1'b1, 64'h1234567890123456, 64'h0000000000000001, 1'b0, 1'b0,
             "R2 identity");
      run_op(1'b1, 64'h5000000000000000, 64'h0000000000000002, 1'b0, 1'b0,
             "R6 dropped carry");
      run_op(1'b1, 64'h0000000000000005, 64'h0000000000000024, 1'b1, 1'b1,
             "R5 R9 disturbed wide");
      run_op(1'b1, 64'h0000000987654321, 64'h0000000000888888, 1'b0, 1'b0,
             "R7 long run");
      run_op(1'b0, to_bcd2(47), to_bcd2(36), 1'b1, 1'b1, "R5 R9 disturbed small");

      // sweep over the two-digit instance
      for (int x = 0; x < 100; x++)
         for (int y = 0; y < 10; y++)
            run_op(1'b0, to_bcd2(x), to_bcd2(y), 1'b0, 1'b0, "R2 one-digit sweep");
      for (int x = 0; x < 100; x++)
         for (int y = 10; y < 100; y += 9)
            run_op(1'b0, to_bcd2(x), to_bcd2(y), 1'b0, 1'b0, "R6 two-digit sweep");
      run_op(1'b0, to_bcd2(99), to_bcd2(99), 1'b0, 1'b1, "R6 small nines");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule